// File: doc/BRIEF.md
# Sliding-Window Median Filter

This block smooths a stream of signed 16-bit samples from one channel. It keeps the most recent `WIN` samples and produces their median each time a new sample arrives. The input is a valid/data pair and the output is a valid/median pair. `WIN` is a parameter and defaults to 5. To filter two channels, instantiate the block twice.

The samples are held in ascending order at all times. Each entry carries an age slot number. A new sample takes the place of the entry whose slot matches a circular age pointer, so one update is an evict and an insert done together in a single clock. Nothing is re-sorted. Before `WIN` samples have arrived, the empty positions hold zero. For an odd window the result is the middle entry. For an even window it is the floor of the mean of the two middle entries.

The median appears two clock edges after the sample is accepted. A new sample can be accepted on every cycle.

Top module: `medf_sliding_median`

## Requirements
- R1: While reset is active, and until the first result, `out_valid` is 0 and `out_median` is 0.
- R2: Each cycle with `in_valid` high produces exactly one `out_valid` pulse, and nothing else does. The pulse is high in the cycle after the second rising edge that follows the accepted sample, a latency of 2 edges.
- R3: For odd `WIN`, `out_median` is element `(WIN-1)/2` of the last `WIN` accepted samples sorted in ascending order, where element 0 is the smallest. The comparison treats samples as two's-complement signed values.
- R4: Until `WIN` samples have been accepted, each missing sample counts as a zero value in the window.
- R5: For even `WIN`, `out_median` is floor((a+b)/2) of the two middle sorted values. The sum is formed in 17 bits and shifted right arithmetically, so the result rounds toward negative infinity and cannot overflow at full-scale inputs.
- R6: Each new sample evicts exactly the oldest sample, and this holds even when several samples in the window have equal values.
- R7: Samples accepted on consecutive cycles each produce their own correct result, on consecutive cycles.
- R8: `out_median` changes only in a cycle where `out_valid` is high, and holds its value otherwise.
- R9: Cycles with `in_valid` low leave the window unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Its release is synchronised inside the block. |
| in_valid | input | 1 | Sample strobe |
| in_data | input | DATA_W | New sample, two's-complement signed |
| out_valid | output | 1 | Result strobe, one pulse per sample |
| out_median | output | DATA_W | Median of the current window, signed |

## Verification
The checker watches several properties on every cycle:
- The window contents stay in ascending signed order.
- The age slots always form a full permutation, so exactly one entry is the oldest.
- Each accepted sample yields exactly one result strobe two edges later.
- The output is quiet in reset and holds its value between strobes.

Whether the right values come out can only be shown by the bench scenarios, which compare against a model of the last `WIN` samples. These scenarios cover the zero padding after reset, signed ordering, eviction among duplicates, floor rounding of the even-window mean at full scale, idle gaps and back-to-back streams.

// File: rtl/medf_pkg.sv
package medf_pkg;
  localparam int unsigned SAMPLE_W_DEF = 16;
  localparam int unsigned WIN_DEF      = 5;

  // Width of an age slot or a sorted position for a window of n entries.
  function automatic int unsigned slot_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/medf_rst_sync.sv
module medf_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic stage_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      hold_q  <= stage_q;
    end
  end

  assign rst_n_out = hold_q;
endmodule

// File: rtl/medf_rank_locate.sv
// Finds where the oldest entry sits in the sorted window, and the position
// the new sample will take once that entry is gone.
module medf_rank_locate #(
  parameter int unsigned WIN    = 5,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SLOT_W = 3
) (
  input  logic signed [DATA_W-1:0] vals     [WIN],
  input  logic        [SLOT_W-1:0] slots    [WIN],
  input  logic        [SLOT_W-1:0] age_ptr,
  input  logic signed [DATA_W-1:0] new_val,
  output logic        [SLOT_W-1:0] evict_idx,
  output logic        [SLOT_W-1:0] ins_pos
);
  always_comb begin
    evict_idx = '0;
    for (int j = 0; j < WIN; j++) begin
      if (slots[j] == age_ptr) evict_idx = SLOT_W'(j);
    end
  end

  // Count the surviving entries that are strictly smaller than the new sample.
  always_comb begin
    ins_pos = '0;
    for (int j = 0; j < WIN; j++) begin
      if ((slots[j] != age_ptr) && (vals[j] < new_val)) begin
        ins_pos = ins_pos + SLOT_W'(1);
      end
    end
  end
endmodule

// File: rtl/medf_sorted_window.sv
// Holds the window in ascending order. Each entry carries the age slot it
// was written into. One accepted sample shifts part of the array by one
// place to close the evicted gap and open the insert gap.
module medf_sorted_window #(
  parameter int unsigned WIN    = 5,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SLOT_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_en,
  input  logic signed [DATA_W-1:0] new_val,
  output logic signed [DATA_W-1:0] vals_q   [WIN],
  output logic        [SLOT_W-1:0] slots_q  [WIN],
  output logic        [SLOT_W-1:0] age_ptr_q
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(WIN - 1);

  logic        [SLOT_W-1:0] evict_idx;
  logic        [SLOT_W-1:0] ins_pos;
  logic signed [DATA_W-1:0] vals_nxt  [WIN];
  logic        [SLOT_W-1:0] slots_nxt [WIN];
  logic        [SLOT_W-1:0] age_ptr_nxt;

  medf_rank_locate #(
    .WIN   (WIN),
    .DATA_W(DATA_W),
    .SLOT_W(SLOT_W)
  ) u_locate (
    .vals     (vals_q),
    .slots    (slots_q),
    .age_ptr  (age_ptr_q),
    .new_val  (new_val),
    .evict_idx(evict_idx),
    .ins_pos  (ins_pos)
  );

  // Per position: take the new sample, or an old entry from the same
  // place, the place above, or the place below.
  for (genvar g = 0; g < WIN; g++) begin : g_pos
    logic [SLOT_W-1:0] src_idx;
    logic              take_new;

    always_comb begin
      if (g < int'(ins_pos)) begin
        src_idx = (g < int'(evict_idx)) ? SLOT_W'(g) : SLOT_W'(g + 1);
      end else begin
        src_idx = ((g - 1) < int'(evict_idx)) ? SLOT_W'(g - 1) : SLOT_W'(g);
      end
    end

    assign take_new     = (g == int'(ins_pos));
    assign vals_nxt[g]  = take_new ? new_val   : vals_q[src_idx];
    assign slots_nxt[g] = take_new ? age_ptr_q : slots_q[src_idx];
  end

  always_comb begin
    age_ptr_nxt = (age_ptr_q == LAST_SLOT) ? '0 : age_ptr_q + SLOT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN; i++) begin
        vals_q[i]  <= '0;
        slots_q[i] <= SLOT_W'(i);
      end
      age_ptr_q <= '0;
    end else if (load_en) begin
      for (int i = 0; i < WIN; i++) begin
        vals_q[i]  <= vals_nxt[i];
        slots_q[i] <= slots_nxt[i];
      end
      age_ptr_q <= age_ptr_nxt;
    end
  end
endmodule

// File: rtl/medf_mid_select.sv
// Floor of the mean of two middle values. For an odd window both inputs
// are the same entry, and the mean is that entry.
module medf_mid_select #(
  parameter int unsigned DATA_W = 16
) (
  input  logic signed [DATA_W-1:0] lo_val,
  input  logic signed [DATA_W-1:0] hi_val,
  output logic signed [DATA_W-1:0] mid_val
);
  logic signed [DATA_W:0] pair_sum;

  assign pair_sum = {lo_val[DATA_W-1], lo_val} + {hi_val[DATA_W-1], hi_val};
  assign mid_val  = pair_sum[DATA_W:1];
endmodule

// File: rtl/medf_sliding_median.sv
module medf_sliding_median #(
  parameter int unsigned WIN    = medf_pkg::WIN_DEF,
  parameter int unsigned DATA_W = medf_pkg::SAMPLE_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_median
);
  localparam int unsigned SLOT_W = medf_pkg::slot_width(WIN);
  localparam int unsigned LO_IDX = (WIN - 1) / 2;
  localparam int unsigned HI_IDX = WIN / 2;

  logic                     rst_sync_n;
  logic signed [DATA_W-1:0] sort_val  [WIN];
  logic        [SLOT_W-1:0] sort_slot [WIN];
  logic        [SLOT_W-1:0] age_ptr;
  logic signed [DATA_W-1:0] mid_val;
  logic                     upd_q;
  logic                     out_valid_q;
  logic        [DATA_W-1:0] out_median_q;
  logic        [DATA_W-1:0] out_median_nxt;

  medf_rst_sync u_rst_sync (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_sync_n)
  );

  medf_sorted_window #(
    .WIN   (WIN),
    .DATA_W(DATA_W),
    .SLOT_W(SLOT_W)
  ) u_window (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_en  (in_valid),
    .new_val  (signed'(in_data)),
    .vals_q   (sort_val),
    .slots_q  (sort_slot),
    .age_ptr_q(age_ptr)
  );

  medf_mid_select #(
    .DATA_W(DATA_W)
  ) u_mid (
    .lo_val (sort_val[LO_IDX]),
    .hi_val (sort_val[HI_IDX]),
    .mid_val(mid_val)
  );

  // Output stage: register the middle value one edge after the window update.
  always_comb begin
    out_median_nxt = upd_q ? DATA_W'(mid_val) : out_median_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      upd_q        <= 1'b0;
      out_valid_q  <= 1'b0;
      out_median_q <= '0;
    end else begin
      upd_q        <= in_valid;
      out_valid_q  <= upd_q;
      out_median_q <= out_median_nxt;
    end
  end

  assign out_valid  = out_valid_q;
  assign out_median = out_median_q;
endmodule

// File: rtl/medf_sliding_median_chk.sv
module medf_sliding_median_chk #(
  parameter int unsigned WIN    = 5,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SLOT_W = 3
) (
  input logic                     clk,
  input logic                     rst_sync_n,
  input logic                     in_valid,
  input logic                     out_valid,
  input logic        [DATA_W-1:0] out_median,
  input logic signed [DATA_W-1:0] sort_val  [WIN],
  input logic        [SLOT_W-1:0] sort_slot [WIN]
);
  logic [WIN-1:0] slot_seen;

  always_comb begin
    slot_seen = '0;
    for (int i = 0; i < WIN; i++) begin
      if (int'(sort_slot[i]) < WIN) slot_seen[sort_slot[i]] = 1'b1;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_sync_n |-> (!out_valid && out_median == '0));

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |-> ##2 out_valid);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |-> ##2 !out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !out_valid |-> $stable(out_median));

  p_age_perm_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    slot_seen == {WIN{1'b1}});

  for (genvar g = 0; g + 1 < WIN; g++) begin : g_order
    p_ascending_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
      sort_val[g] <= sort_val[g+1]);
  end
endmodule

bind medf_sliding_median medf_sliding_median_chk #(
  .WIN   (WIN),
  .DATA_W(DATA_W),
  .SLOT_W(SLOT_W)
) u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_median(out_median),
  .sort_val  (sort_val),
  .sort_slot (sort_slot)
);

// File: tb/medf_sliding_median_tb_top.sv
`timescale 1ns/1ps
module medf_sliding_median_tb_top;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_data;
  logic        ov5, ov4;
  logic [15:0] med5_raw, med4_raw;
  logic signed [15:0] med5, med4;

  int n_cmp;
  int n_bad;
  bit done;

  // Model state: the last five and the last four samples, both starting at zero.
  int h5 [5];
  int h4 [4];
  int p5, p4;
  int q5 [$];
  int q4 [$];
  logic [31:0] seed;

  assign med5 = signed'(med5_raw);
  assign med4 = signed'(med4_raw);

  medf_sliding_median #(.WIN(5), .DATA_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(ov5), .out_median(med5_raw)
  );

  medf_sliding_median #(.WIN(4), .DATA_W(16)) dut_even_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(ov4), .out_median(med4_raw)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int model_median(input int n, input int src [8]);
    int a [8];
    int t;
    for (int i = 0; i < 8; i++) a[i] = src[i];
    for (int i = 1; i < n; i++) begin
      for (int j = i; j > 0; j--) begin
        if (a[j] < a[j-1]) begin t = a[j]; a[j] = a[j-1]; a[j-1] = t; end
      end
    end
    return (a[(n-1)/2] + a[n/2]) >>> 1;
  endfunction

  function automatic int exp5();
    int s [8];
    for (int i = 0; i < 8; i++) s[i] = (i < 5) ? h5[i] : 0;
    return model_median(5, s);
  endfunction

  function automatic int exp4();
    int s [8];
    for (int i = 0; i < 8; i++) s[i] = (i < 4) ? h4[i] : 0;
    return model_median(4, s);
  endfunction

  task automatic model_push(input int v);
    h5[p5] = v; p5 = (p5 + 1) % 5;
    h4[p4] = v; p4 = (p4 + 1) % 4;
  endtask

  // One isolated sample, with a latency and single-pulse check on both instances.
  task automatic send_one(input string tag, input int v);
    int e5, e4;
    model_push(v);
    e5 = exp5();
    e4 = exp4();
    @(negedge clk); in_valid = 1'b1; in_data = 16'(v);
    @(negedge clk); in_valid = 1'b0;
    chk("R2", "early strobe odd", int'(ov5), 0);
    chk("R2", "early strobe even", int'(ov4), 0);
    @(negedge clk);
    chk("R2", "strobe odd", int'(ov5), 1);
    chk("R2", "strobe even", int'(ov4), 1);
    chk(tag, "median odd", int'(med5), e5);
    chk(tag, "median even", int'(med4), e4);
    @(negedge clk);
    chk("R2", "single pulse odd", int'(ov5), 0);
    chk("R2", "single pulse even", int'(ov4), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", int'(ov5) + int'(ov4), 0);
    chk("R1", "median in reset", int'(med5) + int'(med4), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "valid after reset", int'(ov5) + int'(ov4), 0);
    chk("R1", "median after reset", int'(med5), 0);
  endtask

  task automatic t_padding();
    // First samples share the window with zeros: R4
    send_one("R4", 7);
    send_one("R4", -3);
    send_one("R4", 12);
    send_one("R4", 9);
  endtask

  task automatic t_signed_order();
    // R3: negatives must sort below positives
    send_one("R3", -200);
    send_one("R3", 150);
    send_one("R3", -32768);
    send_one("R3", 32767);
    send_one("R3", -1);
    send_one("R3", 4);
  endtask

  task automatic t_duplicates();
    // R6: equal values, then distinct ones must push each duplicate out in age order
    for (int i = 0; i < 5; i++) send_one("R6", 9);
    send_one("R6", 1);
    send_one("R6", 2);
    send_one("R6", 9);
    send_one("R6", 30);
    send_one("R6", 31);
    send_one("R6", 32);
  endtask

  task automatic t_even_round();
    // R5: the even window {-1,0,...} and {3,4} round toward negative infinity
    send_one("R5", -1); send_one("R5", -1); send_one("R5", 0); send_one("R5", 0);
    send_one("R5", 3);  send_one("R5", 4);  send_one("R5", 3); send_one("R5", 4);
    for (int i = 0; i < 5; i++) send_one("R5", 32767);
    for (int i = 0; i < 5; i++) send_one("R5", -32768);
  endtask

  task automatic t_idle_gap();
    int held;
    held = int'(med5);
    repeat (12) @(negedge clk);
    chk("R8", "median held odd", int'(med5), held);
    chk("R2", "no strobe when idle", int'(ov5) + int'(ov4), 0);
    // R9: the window survived the gap; the next result uses it
    send_one("R9", 100);
  endtask

  task automatic t_stream();
    int len;
    int v;
    len = 24;
    for (int i = 0; i < len + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk("R7", "stream strobe", int'(ov5) + int'(ov4), 2);
        chk("R7", "stream median odd", int'(med5), q5.pop_front());
        chk("R7", "stream median even", int'(med4), q4.pop_front());
      end
      if (i < len) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        v = int'(signed'(seed[30:15]));
        model_push(v);
        q5.push_back(exp5());
        q4.push_back(exp4());
        in_valid = 1'b1;
        in_data  = 16'(v);
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk("R2", "stream ends quiet", int'(ov5) + int'(ov4), 0);
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    p5 = 0; p4 = 0; seed = 32'h1234_5678;
    for (int i = 0; i < 5; i++) h5[i] = 0;
    for (int i = 0; i < 4; i++) h4[i] = 0;
    t_reset();
    t_padding();
    t_signed_order();
    t_duplicates();
    t_even_round();
    t_idle_gap();
    t_stream();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule